// File: doc/BRIEF.md
# Sampling Converter Readout Slave (Chip-Select Mode, Three-Wire)

This block is the digital half of a 16-bit sampling converter that answers a serial host over three wires: a conversion trigger, a serial clock and a serial data output. The configuration input is tied high to select chip-select operation. A rising edge on the trigger starts a conversion of fixed length. A counter in the system clock domain models the converter's busy time. When that time is up, the block captures the parallel sample word and returns to acquisition, shown by a status flag. It then presents the captured result on the serial output, most significant bit first, while the trigger is held low.

The serial output is modelled as a data bit plus an output enable; a low enable means high impedance. The trigger and serial clock arrive asynchronously. Each passes a two-stage synchronizer and an edge detector clocked by the system clock. The parallel sample has no handshake. It is taken in the single cycle in which the conversion ends, so the source must hold it valid then. The serial host paces the readout entirely through its clock edges. There is no back-pressure in either direction.

Top module: `adc_cs_readout`

## Requirements
- R1: After reset, `acq_idle` is 1 and `ser_out_en` is 0.
- R2: With `mode_cfg` at 1, a rising edge on `conv_trig` starts a conversion. Three clock edges after the input changes, `acq_idle` is 0 and `ser_out_en` is 0.
- R3: A conversion lasts exactly `CONV_CYCLES` clock cycles. Further edges on `conv_trig` during the conversion neither restart nor stop it. `acq_idle` returns to 1 on clock edge `CONV_CYCLES`+3 after the starting input change.
- R4: With `mode_cfg` at 0, a rising edge on `conv_trig` starts no conversion, and `acq_idle` stays 1.
- R5: `ser_out_en` is 1 only while the block is in acquisition, an unread result is held, and the synchronized `conv_trig` is low. `ser_out` then carries bit 15 of the result first. If `conv_trig` is already low when the conversion ends, the output is enabled on that same clock edge.
- R6: Each synchronized falling edge of `ser_clk` while `ser_out_en` is 1 moves the next lower result bit onto `ser_out`. Falling edges while `ser_out_en` is 0 have no effect on the result still to be read.
- R7: `ser_out` does not change across a rising edge of `ser_clk`, so the host may sample on either edge.
- R8: After the 16th falling edge, `ser_out_en` goes to 0 and stays 0 under further `ser_clk` edges until a new conversion completes.
- R9: A rising `conv_trig` during readout sets `ser_out_en` to 0 within two clock edges and starts the next conversion.
- R10: The result is the value of `sample_in` in the cycle in which the conversion completes. Changes to `sample_in` before or after that cycle do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_trig | input | 1 | Conversion trigger and readout select (asynchronous) |
| ser_clk | input | 1 | Serial clock from the host (asynchronous) |
| mode_cfg | input | 1 | Mode configuration; 1 selects chip-select operation |
| sample_in | input | RES_BITS | Parallel result taken at conversion end |
| ser_out | output | 1 | Serial data bit |
| ser_out_en | output | 1 | Serial output enable; 0 means high impedance |
| acq_idle | output | 1 | 1 while in acquisition (powered down), 0 while converting |

## Verification
The bench probes the two ends of the conversion window by cycle. A timer that is one cycle short or long makes `acq_idle` rise at the wrong sample. A design that restarts on every trigger edge ends its conversion late when the trigger is toggled mid-conversion. It also checks the two ways a readout ends. A design that misses the 16th-edge release keeps driving after the last bit. A design that ignores a mid-readout trigger rise keeps driving into the next conversion. Serial clock pulses sent while the output is disabled, and sample changes on both sides of completion, expose a shifter that moves when it should not and a capture taken at the wrong moment.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum int {
    PIN_TRIG = 0,
    PIN_SCLK = 1
  } pin_idx_e;
  localparam int NUM_PINS = 2;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din[i]};
    end
    assign level[i] = chain[STAGES-1];
    assign rise[i]  = chain[STAGES-1] & ~chain[STAGES];
    assign fall[i]  = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
  parameter int BITS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    abort,
  input  logic                    load,
  input  logic [BITS-1:0]         load_data,
  input  logic                    shift,
  output logic                    msb,
  output logic                    avail,
  output logic [$clog2(BITS)-1:0] bit_cnt
);
  localparam int BCW = $clog2(BITS);
  localparam logic [BCW-1:0] LASTB = BCW'(BITS - 1);

  logic [BITS-1:0] shreg;

  assign msb = shreg[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      avail   <= 1'b0;
      bit_cnt <= '0;
    end else if (abort) begin
      avail <= 1'b0;
    end else if (load) begin
      shreg   <= load_data;
      avail   <= 1'b1;
      bit_cnt <= '0;
    end else if (shift) begin
      shreg   <= {shreg[BITS-2:0], 1'b0};
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == LASTB) avail <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_cs_readout.sv
module adc_cs_readout
  import adc_rd_pkg::*;
#(
  parameter int RES_BITS    = 16,
  parameter int CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_trig,
  input  logic                ser_clk,
  input  logic                mode_cfg,
  input  logic [RES_BITS-1:0] sample_in,
  output logic                ser_out,
  output logic                ser_out_en,
  output logic                acq_idle
);
  localparam int BCW = $clog2(RES_BITS);

  logic [NUM_PINS-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  logic trig_lvl, trig_rise, sck_fall;
  logic busy, conv_done, start, avail, shift_en;
  logic [BCW-1:0] bit_cnt;

  always_comb begin
    pin_raw           = '0;
    pin_raw[PIN_TRIG] = conv_trig;
    pin_raw[PIN_SCLK] = ser_clk;
  end

  adc_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_raw),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign trig_lvl  = pin_lvl[PIN_TRIG];
  assign trig_rise = pin_rise[PIN_TRIG];
  assign sck_fall  = pin_fall[PIN_SCLK];
  assign start     = trig_rise & mode_cfg;

  adc_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(conv_done)
  );

  assign ser_out_en = avail & ~trig_lvl & ~busy;
  assign shift_en   = sck_fall & ser_out_en;
  assign acq_idle   = ~busy;

  adc_shift_out #(.BITS(RES_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(trig_rise), .load(conv_done),
    .load_data(sample_in), .shift(shift_en), .msb(ser_out),
    .avail(avail), .bit_cnt(bit_cnt)
  );
endmodule

// File: rtl/adc_cs_readout_chk.sv
module adc_cs_readout_chk #(
  parameter int BITS = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mode_cfg,
  input logic                    ser_out,
  input logic                    ser_out_en,
  input logic                    acq_idle,
  input logic                    trig_rise,
  input logic                    sck_fall,
  input logic                    busy,
  input logic                    conv_done,
  input logic [$clog2(BITS)-1:0] bit_cnt
);
  localparam int BCW = $clog2(BITS);
  localparam logic [BCW-1:0] LASTB = BCW'(BITS - 1);

  p_start_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rise && mode_cfg && acq_idle) |=> !acq_idle);

  p_conv_persists_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> busy);

  p_no_conv_cfg_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rise && !mode_cfg && acq_idle) |=> acq_idle);

  p_drive_in_acq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out_en |-> acq_idle);

  p_stable_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out_en && !sck_fall && !trig_rise) |=> $stable(ser_out));

  p_release_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out_en && sck_fall && bit_cnt == LASTB) |=> !ser_out_en);
endmodule

bind adc_cs_readout adc_cs_readout_chk #(.BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .ser_out(ser_out),
  .ser_out_en(ser_out_en), .acq_idle(acq_idle), .trig_rise(trig_rise),
  .sck_fall(sck_fall), .busy(busy), .conv_done(conv_done), .bit_cnt(bit_cnt)
);

// File: tb/adc_cs_readout_test.sv
module adc_cs_readout_test;
  localparam int N = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_trig = 1'b0;
  logic ser_clk = 1'b0;
  logic mode_cfg = 1'b1;
  logic [15:0] sample_in = '0;
  logic ser_out, ser_out_en, acq_idle;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  adc_cs_readout #(.RES_BITS(16), .CONV_CYCLES(N)) uut (
    .clk(clk), .rst_n(rst_n), .conv_trig(conv_trig), .ser_clk(ser_clk),
    .mode_cfg(mode_cfg), .sample_in(sample_in), .ser_out(ser_out),
    .ser_out_en(ser_out_en), .acq_idle(acq_idle)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Reads n bits, starting with MSB already on the output.
  task automatic read_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ser_clk = 1'b1;
      step(4);
      check("R7", "bit held over rising edge", ser_out, w[15-i]);
      ser_clk = 1'b0;
      step(4);
      if (i < 15) begin
        check("R6", "enable during shift", ser_out_en, 1'b1);
        check("R6", "next bit", ser_out, w[14-i]);
      end else begin
        check("R8", "release after 16th fall", ser_out_en, 1'b0);
      end
    end
  endtask

  task automatic t_reset;
    step(1);
    check("R1", "acq after reset", acq_idle, 1'b1);
    check("R1", "enable after reset", ser_out_en, 1'b0);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic t_basic;
    sample_in = 16'hFFFF;
    conv_trig = 1'b1;
    step(3);
    check("R2", "converting", acq_idle, 1'b0);
    check("R2", "hi-z at start", ser_out_en, 1'b0);
    step(4);
    sample_in = 16'hA5C3;
    step(N - 6);
    check("R3", "still converting at N+1", acq_idle, 1'b0);
    step(2);
    check("R3", "done at N+3", acq_idle, 1'b1);
    check("R5", "hi-z while trigger high", ser_out_en, 1'b0);
    sample_in = 16'h0000;
    conv_trig = 1'b0;
    step(3);
    check("R5", "enabled on trigger low", ser_out_en, 1'b1);
    check("R10", "msb of latched sample", ser_out, 1'b1);
    read_bits(16'hA5C3, 16);
    ser_clk = 1'b1; step(4); ser_clk = 1'b0; step(4);
    check("R8", "stays off on extra fall", ser_out_en, 1'b0);
  endtask

  task automatic t_toggle_during_conv;
    sample_in = 16'h8001;
    conv_trig = 1'b1; step(4);
    conv_trig = 1'b0; step(4);
    check("R5", "off while converting with trigger low", ser_out_en, 1'b0);
    conv_trig = 1'b1; step(4);
    conv_trig = 1'b0;
    step(N + 1 - 12);
    check("R3", "no restart: busy at N+1", acq_idle, 1'b0);
    check("R5", "off before completion", ser_out_en, 1'b0);
    step(2);
    check("R3", "no restart: idle at N+3", acq_idle, 1'b1);
    check("R5", "immediate drive at completion", ser_out_en, 1'b1);
    check("R5", "immediate msb", ser_out, 1'b1);
    read_bits(16'h8001, 16);
  endtask

  task automatic t_abort;
    sample_in = 16'h3C5A;
    conv_trig = 1'b1; step(N + 4);
    conv_trig = 1'b0; step(3);
    check("R5", "msb 0 word", ser_out, 1'b0);
    read_bits(16'h3C5A, 5);
    conv_trig = 1'b1;
    step(2);
    check("R9", "off two edges after trigger", ser_out_en, 1'b0);
    step(1);
    check("R9", "next conversion started", acq_idle, 1'b0);
    sample_in = 16'hC00F;
    for (int k = 0; k < 2; k++) begin
      ser_clk = 1'b1; step(3); ser_clk = 1'b0; step(3);
    end
    step(N);
    conv_trig = 1'b0;
    step(3);
    check("R6", "falls while off ignored: enable", ser_out_en, 1'b1);
    check("R6", "falls while off ignored: msb", ser_out, 1'b1);
    read_bits(16'hC00F, 16);
  endtask

  task automatic t_cfg_low;
    mode_cfg = 1'b0;
    conv_trig = 1'b1;
    step(4);
    check("R4", "no conversion with cfg low", acq_idle, 1'b1);
    step(N);
    check("R4", "still idle", acq_idle, 1'b1);
    check("R4", "output off", ser_out_en, 1'b0);
    conv_trig = 1'b0;
    step(4);
    check("R4", "no data without conversion", ser_out_en, 1'b0);
    mode_cfg = 1'b1;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_toggle_during_conv();
    t_abort();
    t_cfg_low();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule